// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two IEEE 754 binary32 operands and returns a correctly rounded binary32 sum together with four sticky-free exception flags: invalid, overflow, underflow and inexact. The flags are reported with each result and no trap is taken. To subtract, the caller inverts the sign bit of the second operand before presenting it. The adder has no separate subtract mode.

Each operand is first sorted into a class: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. When either operand is not a nonzero finite number, the result comes from a table indexed by the pair of classes. Otherwise the operands go through the finite path. That path aligns the significands using three extra low bits (guard, round, sticky), adds or subtracts the magnitudes, normalizes the result and rounds it in one of four modes. A flush input makes subnormal inputs count as signed zeros. All results are registered, so each sum appears one clock after its operands.

Top module: `fp32_adder`

## Requirements
- R1: If either operand is a signaling NaN, the result is the fixed NaN 0x7FBFFFFF and invalid is raised. A NaN is an encoding with exponent field 255 and a nonzero fraction. It is signaling when fraction bit 22 is set and quiet when bit 22 is clear.
- R2: If neither operand is signaling and op_x is a quiet NaN, the result is op_x bit for bit. Otherwise, if op_y is a quiet NaN, the result is op_y. No flag is raised in either case.
- R3: Two infinities of equal sign return op_x. Two infinities of opposite sign return 0x7FBFFFFF and raise invalid. An infinity paired with any zero or finite operand is returned unchanged, with no flags.
- R4: Two zeros of equal sign return op_x. An exactly zero sum of operands with opposite signs, whether both are zeros or the operands cancel, is -0 (0x80000000) in rounding mode 3 and +0 in every other mode. No flags are raised.
- R5: A nonzero finite operand added to a zero is returned bit for bit, with no flags.
- R6: With flush_en high, a subnormal input (exponent field 0, nonzero fraction) behaves as a zero carrying the same sign. With flush_en low, a subnormal input contributes its exact value.
- R7: Nonzero finite sums are correctly rounded according to rnd_mode: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity. Inexact is raised exactly when the rounded result differs from the exact sum.
- R8: When the rounded exponent would exceed 254, overflow and inexact are raised. The result is infinity in mode 0, in mode 2 for a positive sum and in mode 3 for a negative sum. In all other cases it is the largest finite magnitude (exponent 254, fraction all ones) with the sign of the sum.
- R9: Underflow is raised only when the sum is below the smallest normal magnitude before rounding and is also inexact. An exact subnormal result raises no flag.
- R10: The result and flags are registered: they reflect the operands and mode present at the previous rising clock edge. While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_x | input | 32 | First binary32 operand |
| op_y | input | 32 | Second binary32 operand (sign inverted by the caller to subtract) |
| rnd_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| flush_en | input | 1 | Treat subnormal inputs as signed zeros |
| sum_o | output | 32 | Registered binary32 result |
| flag_invalid | output | 1 | Invalid operation for this result |
| flag_overflow | output | 1 | Overflow for this result |
| flag_underflow | output | 1 | Underflow (tiny and inexact) for this result |
| flag_inexact | output | 1 | Rounded result differs from the exact sum |

## Verification
The result and all four flags for a set of operands are due at the first rising clock edge after those operands are applied, with one register stage and nothing else in between. The bench changes inputs on the falling edge and reads the outputs 1 ns after the next rising edge, so every comparison lands in the cycle where the result becomes valid. One dedicated check reads the outputs just before that edge and confirms they still hold the previous result. Expected values come from an exact wide-integer model of the sum and are compared against directed special-class pairs and several thousand random operand pairs with random rounding modes.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int GRS_W  = 3;
  localparam int EXT_W  = SIG_W + GRS_W;
  localparam int SUM_W  = EXT_W + 1;
  localparam int ECALC_W = EXP_W + 1;
  localparam int SH_W   = $clog2(EXT_W + 1);
  localparam int NUM_OPS = 2;

  localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
  localparam logic [EXP_W-1:0] EXP_MAXF = EXP_ALL1 - 1'b1;
  localparam logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FBF_FFFF;

  localparam logic [1:0] RM_NEAREST = 2'd0;
  localparam logic [1:0] RM_TOZERO  = 2'd1;
  localparam logic [1:0] RM_TOPOS   = 2'd2;
  localparam logic [1:0] RM_TONEG   = 2'd3;

  typedef enum logic [2:0] {
    CL_ZERO, CL_NORM, CL_SUBN, CL_INF, CL_QNAN, CL_SNAN
  } fp_class_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
    fp_class_e         cls;
  } fp_opnd_t;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;
endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] raw_i,
  input  logic              flush_i,
  output fp_opnd_t          opnd_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = raw_i[WORD_W-2 -: EXP_W];
  assign frac_f = raw_i[FRAC_W-1:0];

  always_comb begin
    opnd_o.sign = raw_i[WORD_W-1];
    opnd_o.exp  = exp_f;
    opnd_o.frac = frac_f;
    if (exp_f == EXP_ALL1) begin
      if (frac_f == '0)          opnd_o.cls = CL_INF;
      else if (frac_f[FRAC_W-1]) opnd_o.cls = CL_SNAN;
      else                       opnd_o.cls = CL_QNAN;
    end else if (exp_f == '0) begin
      if (frac_f == '0) begin
        opnd_o.cls = CL_ZERO;
      end else if (flush_i) begin
        opnd_o.cls  = CL_ZERO;
        opnd_o.frac = '0;
      end else begin
        opnd_o.cls = CL_SUBN;
      end
    end else begin
      opnd_o.cls = CL_NORM;
    end
  end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special
  import fpadd_pkg::*;
(
  input  fp_opnd_t          opx_i,
  input  fp_opnd_t          opy_i,
  input  logic [1:0]        rnd_mode_i,
  output logic              take_o,
  output logic [WORD_W-1:0] value_o,
  output fp_flags_t         flags_o
);
  logic [WORD_W-1:0] word_x, word_y;
  logic same_sign;

  assign word_x    = {opx_i.sign, opx_i.exp, opx_i.frac};
  assign word_y    = {opy_i.sign, opy_i.exp, opy_i.frac};
  assign same_sign = (opx_i.sign == opy_i.sign);

  always_comb begin
    take_o  = 1'b1;
    value_o = word_x;
    flags_o = '0;
    if (opx_i.cls == CL_SNAN || opy_i.cls == CL_SNAN) begin
      value_o         = DEFAULT_NAN;
      flags_o.invalid = 1'b1;
    end else if (opx_i.cls == CL_QNAN) begin
      value_o = word_x;
    end else if (opy_i.cls == CL_QNAN) begin
      value_o = word_y;
    end else if (opx_i.cls == CL_INF && opy_i.cls == CL_INF) begin
      if (!same_sign) begin
        value_o         = DEFAULT_NAN;
        flags_o.invalid = 1'b1;
      end
    end else if (opx_i.cls == CL_INF) begin
      value_o = word_x;
    end else if (opy_i.cls == CL_INF) begin
      value_o = word_y;
    end else if (opx_i.cls == CL_ZERO && opy_i.cls == CL_ZERO) begin
      if (!same_sign) value_o = {(rnd_mode_i == RM_TONEG), {(WORD_W-1){1'b0}}};
    end else if (opy_i.cls == CL_ZERO) begin
      value_o = word_x;
    end else if (opx_i.cls == CL_ZERO) begin
      value_o = word_y;
    end else begin
      take_o = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_finite.sv
module fpadd_finite
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0]  word_x_i,
  input  logic [WORD_W-1:0]  word_y_i,
  output logic               sign_o,
  output logic [ECALC_W-1:0] exp_o,
  output logic [EXT_W-1:0]   sig_o,
  output logic               zero_o
);
  function automatic logic [SH_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [SH_W-1:0] n;
    n = SH_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++) begin
      if (v[i]) n = SH_W'(EXT_W - 1 - i);
    end
    return n;
  endfunction

  logic                x_big;
  logic [WORD_W-1:0]   big_w, sml_w;
  logic [EXP_W-1:0]    e_big, e_sml, diff, lim;
  logic [EXT_W-1:0]    m_big, m_sml, m_al;
  logic [SH_W-1:0]     sh, lz, k;
  logic [2*EXT_W-1:0]  wide;
  logic [SUM_W-1:0]    sum;
  logic                eff_sub;

  assign x_big   = (word_x_i[WORD_W-2:0] >= word_y_i[WORD_W-2:0]);
  assign big_w   = x_big ? word_x_i : word_y_i;
  assign sml_w   = x_big ? word_y_i : word_x_i;
  assign eff_sub = big_w[WORD_W-1] ^ sml_w[WORD_W-1];

  // subnormals keep a zero hidden bit and use exponent 1
  assign e_big = (big_w[WORD_W-2 -: EXP_W] == '0) ? EXP_W'(1) : big_w[WORD_W-2 -: EXP_W];
  assign e_sml = (sml_w[WORD_W-2 -: EXP_W] == '0) ? EXP_W'(1) : sml_w[WORD_W-2 -: EXP_W];
  assign m_big = {(big_w[WORD_W-2 -: EXP_W] != '0), big_w[FRAC_W-1:0], {GRS_W{1'b0}}};
  assign m_sml = {(sml_w[WORD_W-2 -: EXP_W] != '0), sml_w[FRAC_W-1:0], {GRS_W{1'b0}}};

  assign diff = e_big - e_sml;
  assign sh   = (diff > EXP_W'(EXT_W)) ? SH_W'(EXT_W) : diff[SH_W-1:0];
  assign wide = {m_sml, {EXT_W{1'b0}}} >> sh;
  assign m_al = wide[2*EXT_W-1:EXT_W] | {{(EXT_W-1){1'b0}}, |wide[EXT_W-1:0]};

  assign sum = eff_sub ? ({1'b0, m_big} - {1'b0, m_al})
                       : ({1'b0, m_big} + {1'b0, m_al});

  assign lz  = lead_zeros(sum[EXT_W-1:0]);
  assign lim = e_big - 1'b1;
  assign k   = ({{(EXP_W-SH_W){1'b0}}, lz} > lim) ? lim[SH_W-1:0] : lz;

  always_comb begin
    sign_o = big_w[WORD_W-1];
    zero_o = (sum == '0);
    if (sum[SUM_W-1]) begin
      sig_o = {sum[SUM_W-1:2], sum[1] | sum[0]};
      exp_o = {1'b0, e_big} + 1'b1;
    end else begin
      sig_o = sum[EXT_W-1:0] << k;
      exp_o = {1'b0, e_big} - ECALC_W'(k);
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic               sign_i,
  input  logic [ECALC_W-1:0] exp_i,
  input  logic [EXT_W-1:0]   sig_i,
  input  logic [1:0]         rnd_mode_i,
  output logic [WORD_W-1:0]  word_o,
  output fp_flags_t          flags_o
);
  logic [SIG_W-1:0]   keep, mant;
  logic [SIG_W:0]     inc;
  logic [ECALC_W-1:0] e_rnd;
  logic               inexact, up, tiny, to_inf;

  assign keep    = sig_i[EXT_W-1:GRS_W];
  assign inexact = |sig_i[GRS_W-1:0];
  assign tiny    = ~sig_i[EXT_W-1];

  always_comb begin
    case (rnd_mode_i)
      RM_NEAREST: up = sig_i[2] & (sig_i[1] | sig_i[0] | keep[0]);
      RM_TOPOS:   up = ~sign_i & inexact;
      RM_TONEG:   up = sign_i & inexact;
      default:    up = 1'b0;
    endcase
  end

  assign inc    = {1'b0, keep} + (SIG_W+1)'(up);
  assign mant   = inc[SIG_W] ? inc[SIG_W:1] : inc[SIG_W-1:0];
  assign e_rnd  = inc[SIG_W] ? exp_i + 1'b1 : exp_i;
  assign to_inf = (rnd_mode_i == RM_NEAREST) ||
                  (rnd_mode_i == RM_TOPOS && !sign_i) ||
                  (rnd_mode_i == RM_TONEG && sign_i);

  always_comb begin
    flags_o = '0;
    if (e_rnd >= ECALC_W'(EXP_ALL1)) begin
      flags_o.overflow = 1'b1;
      flags_o.inexact  = 1'b1;
      word_o = to_inf ? {sign_i, EXP_ALL1, {FRAC_W{1'b0}}}
                      : {sign_i, EXP_MAXF, {FRAC_W{1'b1}}};
    end else begin
      flags_o.inexact   = inexact;
      flags_o.underflow = tiny & inexact;
      word_o = {sign_i, mant[SIG_W-1] ? e_rnd[EXP_W-1:0] : {EXP_W{1'b0}},
                mant[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] op_x,
  input  logic [31:0] op_y,
  input  logic [1:0]  rnd_mode,
  input  logic        flush_en,
  output logic [31:0] sum_o,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);
  logic [WORD_W-1:0] raw_in [NUM_OPS];
  fp_opnd_t          opnd   [NUM_OPS];
  logic [WORD_W-1:0] fword  [NUM_OPS];

  assign raw_in[0] = op_x;
  assign raw_in[1] = op_y;

  generate
    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_opnd
      fpadd_classify u_cls (
        .raw_i   (raw_in[gi]),
        .flush_i (flush_en),
        .opnd_o  (opnd[gi])
      );
      assign fword[gi] = {opnd[gi].sign, opnd[gi].exp, opnd[gi].frac};
    end
  endgenerate

  logic              spec_take;
  logic [WORD_W-1:0] spec_val;
  fp_flags_t         spec_flags;

  fpadd_special u_spec (
    .opx_i      (opnd[0]),
    .opy_i      (opnd[1]),
    .rnd_mode_i (rnd_mode),
    .take_o     (spec_take),
    .value_o    (spec_val),
    .flags_o    (spec_flags)
  );

  logic               fin_sign, fin_zero;
  logic [ECALC_W-1:0] fin_exp;
  logic [EXT_W-1:0]   fin_sig;

  fpadd_finite u_fin (
    .word_x_i (fword[0]),
    .word_y_i (fword[1]),
    .sign_o   (fin_sign),
    .exp_o    (fin_exp),
    .sig_o    (fin_sig),
    .zero_o   (fin_zero)
  );

  logic [WORD_W-1:0] rnd_word;
  fp_flags_t         rnd_flags;

  fpadd_round u_rnd (
    .sign_i     (fin_sign),
    .exp_i      (fin_exp),
    .sig_i      (fin_sig),
    .rnd_mode_i (rnd_mode),
    .word_o     (rnd_word),
    .flags_o    (rnd_flags)
  );

  logic [WORD_W-1:0] word_d, word_q;
  fp_flags_t         flags_d, flags_q;

  always_comb begin
    if (spec_take) begin
      word_d  = spec_val;
      flags_d = spec_flags;
    end else if (fin_zero) begin
      word_d  = {(rnd_mode == RM_TONEG), {(WORD_W-1){1'b0}}};
      flags_d = '0;
    end else begin
      word_d  = rnd_word;
      flags_d = rnd_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      flags_q <= '0;
    end else begin
      word_q  <= word_d;
      flags_q <= flags_d;
    end
  end

  assign sum_o          = word_q;
  assign flag_invalid   = flags_q.invalid;
  assign flag_overflow  = flags_q.overflow;
  assign flag_underflow = flags_q.underflow;
  assign flag_inexact   = flags_q.inexact;
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] op_x,
  input logic [31:0] op_y,
  input logic [1:0]  rnd_mode,
  input logic [31:0] sum_o,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact
);
  logic x_qnan, y_snan, x_nonnan, y_inf, both_zero_opp;

  assign x_qnan        = (op_x[30:23] == 8'hFF) && (op_x[22:0] != '0) && !op_x[22];
  assign y_snan        = (op_y[30:23] == 8'hFF) && op_y[22];
  assign x_nonnan      = (op_x[30:23] != 8'hFF);
  assign y_inf         = (op_y[30:0] == 31'h7F80_0000);
  assign both_zero_opp = (op_x[30:0] == '0) && (op_y[30:0] == '0) && (op_x[31] != op_y[31]);

  // R1
  invalid_gives_dnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (sum_o == 32'h7FBF_FFFF));

  // R2
  qnan_x_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_qnan && !y_snan) |=> (sum_o == $past(op_x)));

  // R3
  inf_y_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_nonnan && y_inf) |=> (sum_o == $past(op_y)));

  // R4
  opp_zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both_zero_opp |=> (sum_o == {($past(rnd_mode) == 2'd3), 31'h0}));

  // R8
  overflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> flag_inexact);

  // R9
  underflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (flag_inexact && !flag_overflow));
endmodule

bind fp32_adder fpadd_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_x           (op_x),
  .op_y           (op_y),
  .rnd_mode       (rnd_mode),
  .sum_o          (sum_o),
  .flag_invalid   (flag_invalid),
  .flag_overflow  (flag_overflow),
  .flag_underflow (flag_underflow),
  .flag_inexact   (flag_inexact)
);

// File: tb/fp32_adder_tb_top.sv
`timescale 1ns/1ps
module fp32_adder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_x, op_y;
  logic [1:0]  rnd_mode;
  logic        flush_en;
  logic [31:0] sum_o;
  logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [31:0] DNAN = 32'h7FBF_FFFF;

  fp32_adder dut_i (
    .clk(clk), .rst_n(rst_n), .op_x(op_x), .op_y(op_y),
    .rnd_mode(rnd_mode), .flush_en(flush_en), .sum_o(sum_o),
    .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [35:0] observed();
    return {sum_o, flag_invalid, flag_overflow, flag_underflow, flag_inexact};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h flags %b, expected %h flags %b",
               tag, act[35:4], act[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  // Exact model: flags are {invalid, overflow, underflow, inexact}
  task automatic ref_add(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm,
                         input logic fl, output logic [31:0] r, output logic [3:0] f,
                         output string tag);
    logic fx, fy, xs, ys, xq, yq, xi, yi, xz, yz, s, inx, up, tiny, sub_in;
    logic [31:0] xw, yw;
    logic [299:0] a, b, m, sig, rem, half;
    int ex, ey, emin, p, e0, e, sh;
    fx = fl && (x[30:23] == 0) && (x[22:0] != 0);
    fy = fl && (y[30:23] == 0) && (y[22:0] != 0);
    xw = fx ? {x[31], 31'h0} : x;
    yw = fy ? {y[31], 31'h0} : y;
    xs = (xw[30:23] == 8'hFF) && (xw[22:0] != 0) && xw[22];
    ys = (yw[30:23] == 8'hFF) && (yw[22:0] != 0) && yw[22];
    xq = (xw[30:23] == 8'hFF) && (xw[22:0] != 0) && !xw[22];
    yq = (yw[30:23] == 8'hFF) && (yw[22:0] != 0) && !yw[22];
    xi = (xw[30:0] == 31'h7F80_0000);
    yi = (yw[30:0] == 31'h7F80_0000);
    xz = (xw[30:0] == 0);
    yz = (yw[30:0] == 0);
    f = 4'b0000;
    r = xw;
    tag = "R7";
    if (xs || ys) begin
      r = DNAN; f = 4'b1000; tag = "R1";
    end else if (xq) begin
      r = xw; tag = "R2";
    end else if (yq) begin
      r = yw; tag = "R2";
    end else if (xi && yi) begin
      tag = "R3";
      if (xw[31] != yw[31]) begin r = DNAN; f = 4'b1000; end
    end else if (xi) begin
      r = xw; tag = "R3";
    end else if (yi) begin
      r = yw; tag = "R3";
    end else if (xz && yz) begin
      tag = (fx || fy) ? "R6" : "R4";
      r = (xw[31] == yw[31]) ? xw : {(rm == 2'd3), 31'h0};
    end else if (yz) begin
      r = xw; tag = fy ? "R6" : "R5";
    end else if (xz) begin
      r = yw; tag = fx ? "R6" : "R5";
    end else begin
      sub_in = (x[30:23] == 0) || (y[30:23] == 0);
      if (sub_in) tag = "R6";
      ex = (x[30:23] == 0) ? 1 : int'(x[30:23]);
      ey = (y[30:23] == 0) ? 1 : int'(y[30:23]);
      emin = (ex < ey) ? ex : ey;
      a = 300'({(x[30:23] != 0), x[22:0]}) << (ex - emin);
      b = 300'({(y[30:23] != 0), y[22:0]}) << (ey - emin);
      if (x[31] == y[31]) begin m = a + b; s = x[31]; end
      else if (a >= b) begin m = a - b; s = x[31]; end
      else begin m = b - a; s = y[31]; end
      if (m == 0) begin
        r = {(rm == 2'd3), 31'h0}; tag = "R4";
      end else begin
        p = 0;
        for (int i = 0; i < 300; i++) if (m[i]) p = i;
        e0 = emin + p - 23;
        tiny = (e0 < 1);
        e = tiny ? 1 : e0;
        sh = e - emin;
        if (sh <= 0) begin
          sig = m << (-sh); inx = 1'b0; up = 1'b0;
        end else begin
          sig  = m >> sh;
          rem  = m & ((300'b1 << sh) - 300'b1);
          half = 300'b1 << (sh - 1);
          inx  = (rem != 0);
          case (rm)
            2'd0: up = (rem > half) || ((rem == half) && sig[0]);
            2'd2: up = !s && inx;
            2'd3: up = s && inx;
            default: up = 1'b0;
          endcase
        end
        sig = sig + 300'(up);
        if (sig == (300'b1 << 24)) begin sig = 300'b1 << 23; e = e + 1; end
        if (tiny) tag = "R9";
        if (e >= 255) begin
          tag = "R8";
          f = 4'b0101;
          if (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd3 && s)) r = {s, 8'hFF, 23'h0};
          else r = {s, 8'hFE, 23'h7FFFFF};
        end else begin
          r = {s, sig[23] ? 8'(e) : 8'h00, sig[22:0]};
          f = {2'b00, tiny && inx, inx};
        end
      end
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm,
                       input logic fl);
    logic [31:0] er;
    logic [3:0]  ef;
    string       tag;
    ref_add(x, y, rm, fl, er, ef, tag);
    @(negedge clk);
    op_x = x; op_y = y; rnd_mode = rm; flush_en = fl;
    @(posedge clk);
    #1;
    check(tag, observed(), {er, ef});
  endtask

  function automatic logic [31:0] pick_operand(input logic [7:0] near_e, input logic use_near);
    int          sel, e;
    logic        s;
    logic [31:0] fr;
    sel = $urandom_range(0, 19);
    s   = 1'($urandom_range(0, 1));
    fr  = $urandom;
    case (sel)
      0:       return {s, 31'h0};
      1:       return {s, 8'hFF, 23'h0};
      2:       return {s, 8'hFF, 1'b0, fr[21:0] | 22'h1};
      3:       return {s, 8'hFF, 1'b1, fr[21:0]};
      4, 5:    return {s, 8'h00, fr[22:0] | 23'h1};
      default: begin
        if (use_near) e = int'(near_e) + $urandom_range(0, 8) - 4;
        else if (sel > 16) e = $urandom_range(240, 254);
        else e = $urandom_range(1, 254);
        if (e < 1) e = 1;
        if (e > 254) e = 254;
        return {s, 8'(e), fr[22:0]};
      end
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10: watchdog expired, actual still running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] rx, ry, seed_v;
    logic [35:0] prev;
    seed_v = $urandom(32'd20240611);
    rst_n = 1'b0;
    op_x = '0; op_y = '0; rnd_mode = '0; flush_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", observed(), 36'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 signaling NaN in either position
    apply(32'h7FC0_0001, 32'h3F80_0000, 2'd0, 1'b0);
    apply(32'h7F80_0123, 32'hFFC0_0000, 2'd1, 1'b0);
    // R2 quiet NaN priority
    apply(32'h7F81_2345, 32'h3F80_0000, 2'd0, 1'b0);
    apply(32'h3F80_0000, 32'hFF80_0077, 2'd2, 1'b0);
    apply(32'h7F81_0000, 32'hFF80_0077, 2'd0, 1'b0);
    // R3 infinities
    apply(32'h7F80_0000, 32'h7F80_0000, 2'd0, 1'b0);
    apply(32'h7F80_0000, 32'hFF80_0000, 2'd0, 1'b0);
    apply(32'hFF80_0000, 32'h40A0_0000, 2'd3, 1'b0);
    apply(32'h0000_0000, 32'h7F80_0000, 2'd1, 1'b0);
    // R4 zeros and exact cancellation
    apply(32'h0000_0000, 32'h8000_0000, 2'd0, 1'b0);
    apply(32'h0000_0000, 32'h8000_0000, 2'd3, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 2'd2, 1'b0);
    apply(32'h3F80_0000, 32'hBF80_0000, 2'd0, 1'b0);
    apply(32'h3F80_0000, 32'hBF80_0000, 2'd3, 1'b0);
    // R5 nonzero plus zero
    apply(32'h3F80_0001, 32'h0000_0000, 2'd2, 1'b0);
    apply(32'h8000_0000, 32'h0000_0005, 2'd1, 1'b0);
    // R6 flush on and off
    apply(32'h0040_0000, 32'h0040_0000, 2'd0, 1'b0);
    apply(32'h0040_0000, 32'h8040_0000, 2'd0, 1'b1);
    apply(32'h0000_0001, 32'h3F80_0000, 2'd2, 1'b1);
    apply(32'h0000_0001, 32'h3F80_0000, 2'd2, 1'b0);
    // R7 rounding ties and directed modes
    apply(32'h3F80_0000, 32'h3380_0000, 2'd0, 1'b0);
    apply(32'h3F80_0001, 32'h3380_0000, 2'd0, 1'b0);
    apply(32'h3F80_0000, 32'h3380_0000, 2'd2, 1'b0);
    apply(32'hBF80_0000, 32'hB380_0000, 2'd3, 1'b0);
    apply(32'h3F80_0000, 32'hB300_0001, 2'd1, 1'b0);
    // R8 overflow in each mode
    apply(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd0, 1'b0);
    apply(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd1, 1'b0);
    apply(32'hFF7F_FFFF, 32'hFF7F_FFFF, 2'd2, 1'b0);
    apply(32'hFF7F_FFFF, 32'hFF7F_FFFF, 2'd3, 1'b0);
    // R9 exact subnormal differences raise nothing
    apply(32'h0080_0001, 32'h8080_0000, 2'd0, 1'b0);
    apply(32'h0100_0000, 32'h80FF_FFFF, 2'd2, 1'b0);

    // R10 the output holds until the next rising edge
    apply(32'h4000_0000, 32'h4000_0000, 2'd0, 1'b0);
    prev = observed();
    @(negedge clk);
    op_x = 32'h3F80_0000; op_y = 32'h3F80_0000;
    @(posedge clk);
    #0;
    check("R10 hold", observed(), prev);
    #1;
    check("R10 update", observed(), {32'h4000_0000, 4'b0000});

    // random operands, R7 and others by class
    for (int n = 0; n < 4000; n++) begin
      rx = pick_operand(8'd0, 1'b0);
      ry = pick_operand(rx[30:23], ($urandom_range(0, 1) == 1));
      if ($urandom_range(0, 1) == 1) ry = ry ^ 32'h8000_0000;
      apply(rx, ry, 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule